// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is the configuration unit of a disk interface controller. A host reaches sixteen 8-bit configuration registers through four byte ports on a simple synchronous I/O bus. The ports are ID-in, index, data and ID-out. The host writes a register number into the index port, then reads or writes that register through the data port. A one-byte handshake on the ID-in port controls a programming-mode flag.

The block holds the programming-mode flag, the index register, the register file and a sticky detected flag. All of them are driven out as status signals for the surrounding controller. The port block sits at `BASE`, with ports at word steps `BASE+0x0`, `+0x4`, `+0x8` and `+0xC`. The default base is 0x10B0, and 0x1030 is a usable alternative.

Top module: `cfg_index_port`

## Requirements
- R1: While `rst_n` is low and after it rises:
  - `index_o` = 0x80
  - `prog_mode` = 0, `detected` = 0, `rvalid` = 0
  - registers 0 and 1 = 0x8F; registers 2 to 5 = 0xFF; register 6 = 0x80; register 7 = 0x8A; registers 8 to 15 = 0x00
- R2: Only the addresses `BASE+0x0` (ID-in), `BASE+0x4` (index), `BASE+0x8` (data) and `BASE+0xC` (ID-out) are decoded. An access to any other address changes no state. A read of any other address gives `rdata` = 0xFF with `rvalid` low.
- R3: A write to the index port loads `wdata` into the index on the edge that samples `wr`. A read of the index port returns the current index.
- R4: Read results appear on `rdata` with `rvalid` high one clock after the edge that samples `rd`. A data-port read with index 0x80 to 0x8F returns register `index[3:0]`.
- R5: A data-port read with an index below 0x80 or above 0x8F returns 0xFF.
- R6: A data-port write selects register `index[3:0]` and does no range check on the upper index bits.
- R7: Registers 0, 2, 4 and 7 are read-only. Data-port writes to them leave them unchanged.
- R8: Writing 0x00 to ID-in sets `prog_mode`, and writing any other value clears it. Reading ID-in returns 0xFF.
- R9: Reading ID-out returns the chip ID 0x00. Writes to ID-out change no state.
- R10: `detected` is set by the first read of any of the four ports and then stays set until reset. Writes do not set it.
- R11: `prog_mode` is status only. Data-port writes take effect whether it is set or clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | I/O address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rvalid | output | 1 | Read data valid, one clock after a decoded read |
| prog_mode | output | 1 | Programming-mode flag |
| detected | output | 1 | Sticky first-access flag |
| index_o | output | 8 | Current index register |
| regs_o | output | 128 | Register file, register n in bits 8n+7:8n |

## Verification
The data port is read with four kinds of index:
- in-range indexes, which must return the stored byte;
- indexes below 0x80 and above 0x8F, which must return 0xFF and so separate the read range check from the write path;
- an index of 0x93, which must still write register 3, showing that writes ignore the upper nibble;
- indexes that point at read-only registers.

Handshake writes of zero and of a non-zero value show that the programming flag follows the written value and does not gate data writes. Reads and writes to ID-out and to undecoded addresses show that they leave the index and every register untouched.

// File: rtl/cfg_index_port.sv
module cfg_index_port #(
  parameter int AW = 16,
  parameter logic [AW-1:0] BASE = 16'h10B0,
  parameter logic [7:0] CHIP_ID = 8'h00
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr,
  input  logic           rd,
  input  logic           wr,
  input  logic [7:0]     wdata,
  output logic [7:0]     rdata,
  output logic           rvalid,
  output logic           prog_mode,
  output logic           detected,
  output logic [7:0]     index_o,
  output logic [127:0]   regs_o
);
  localparam int NREG = 16;
  localparam logic [NREG-1:0] RO_MASK = 16'h0095;
  localparam logic [7:0] IDX_RST = 8'h80;

  function automatic logic [7:0] rst_val(int n);
    if (n < 2) return 8'h8F;
    else if (n < 6) return 8'hFF;
    else if (n == 6) return 8'h80;
    else if (n == 7) return 8'h8A;
    else return 8'h00;
  endfunction

  logic [7:0] idx;
  logic [7:0] rf [NREG];
  logic [7:0] rd_mux;

  wire sel_idin  = addr == BASE;
  wire sel_index = addr == BASE + AW'(4);
  wire sel_data  = addr == BASE + AW'(8);
  wire sel_idout = addr == BASE + AW'(12);
  wire any_sel   = sel_idin | sel_index | sel_data | sel_idout;
  wire idx_ok    = idx[7:4] == 4'h8;

  assign index_o = idx;

  always_comb begin
    rd_mux = 8'hFF;
    if (sel_index) rd_mux = idx;
    else if (sel_data && idx_ok) rd_mux = rf[idx[3:0]];
    else if (sel_idout) rd_mux = CHIP_ID;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= IDX_RST;
      prog_mode <= 1'b0;
      detected  <= 1'b0;
      rdata     <= 8'hFF;
      rvalid    <= 1'b0;
    end else begin
      rvalid <= rd & any_sel;
      rdata  <= (rd & any_sel) ? rd_mux : 8'hFF;
      if (rd & any_sel) detected <= 1'b1;
      if (wr & sel_idin) prog_mode <= wdata == CHIP_ID;
      if (wr & sel_index) idx <= wdata;
    end
  end

  for (genvar n = 0; n < NREG; n++) begin : g_reg
    if (RO_MASK[n]) begin : g_ro
      always_ff @(posedge clk) rf[n] <= rst_val(n);
    end else begin : g_rw
      always_ff @(posedge clk) begin
        if (!rst_n) rf[n] <= rst_val(n);
        else if (wr && sel_data && idx[3:0] == 4'(n)) rf[n] <= wdata;
      end
    end
    assign regs_o[8*n +: 8] = rf[n];
  end
endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk #(
  parameter int AW = 16,
  parameter logic [AW-1:0] BASE = 16'h10B0
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          rd,
  input logic          wr,
  input logic [7:0]    wdata,
  input logic [7:0]    rdata,
  input logic          rvalid,
  input logic          prog_mode,
  input logic          detected,
  input logic [7:0]    index_o,
  input logic [127:0]  regs_o
);
  wire [31:0] ro_view = {regs_o[63:56], regs_o[39:32], regs_o[23:16], regs_o[7:0]};

  assert_ro_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(ro_view));

  assert_valid_after_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(rd));

  assert_detect_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    detected |=> detected);

  assert_prog_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prog_mode) |-> $past(wr && addr == BASE));

  assert_out_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == BASE + AW'(8) && index_o[7:4] != 4'h8) |=> (rvalid && rdata == 8'hFF));

  assert_index_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == BASE + AW'(4)) |=> index_o == $past(wdata));
endmodule

bind cfg_index_port cfg_index_port_chk #(.AW(AW), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
  .rdata(rdata), .rvalid(rvalid), .prog_mode(prog_mode), .detected(detected),
  .index_o(index_o), .regs_o(regs_o));

// File: tb/test_cfg_index_port.sv
module test_cfg_index_port;
  localparam logic [15:0] B = 16'h10B0;
  localparam logic [15:0] P_IDIN = B, P_IDX = B + 16'h4, P_DAT = B + 16'h8, P_IDOUT = B + 16'hC;

  logic clk = 0;
  logic rst_n = 0;
  logic [15:0] addr = 0;
  logic rd = 0, wr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata, index_o;
  logic rvalid, prog_mode, detected;
  logic [127:0] regs_o;

  always #4 clk = ~clk;

  cfg_index_port i_cfg_index_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .prog_mode(prog_mode), .detected(detected),
    .index_o(index_o), .regs_o(regs_o));

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] m [16];

  function automatic logic [127:0] packm();
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[8*i +: 8] = m[i];
    return v;
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R2 unexpected rvalid act=%h exp=none", rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, 128'(rdata), 128'(e));
      end
    end
  end

  task automatic wr_op(logic [15:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_op(logic [15:0] a, logic [7:0] e, string t);
    @(negedge clk); addr = a; rd = 1; exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd = 0;
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++)
      m[i] = (i < 2) ? 8'h8F : (i < 6) ? 8'hFF : (i == 6) ? 8'h80 : (i == 7) ? 8'h8A : 8'h00;
    repeat (3) @(negedge clk);
    check("R1 index", 128'(index_o), 128'h80);
    check("R1 rvalid", 128'(rvalid), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 flags", 128'({prog_mode, detected}), 0);
    check("R1 regs", regs_o, packm());

    wr_op(P_IDX, 8'h85);
    check("R3 index write", 128'(index_o), 128'h85);
    check("R10 write does not detect", 128'(detected), 0);
    rd_op(P_IDX, 8'h85, "R3 index read");
    check("R10 detected after read", 128'(detected), 1);

    wr_op(P_IDX, 8'h86); rd_op(P_DAT, 8'h80, "R4 data read reg6");
    wr_op(P_IDX, 8'h8F); rd_op(P_DAT, 8'h00, "R4 data read reg15");
    wr_op(P_IDX, 8'h47); rd_op(P_DAT, 8'hFF, "R5 index below range");
    wr_op(P_IDX, 8'h90); rd_op(P_DAT, 8'hFF, "R5 index above range");

    wr_op(P_IDX, 8'h93); wr_op(P_DAT, 8'h5A); m[3] = 8'h5A;
    check("R6 write ignores upper nibble", regs_o, packm());
    wr_op(P_IDX, 8'h83); rd_op(P_DAT, 8'h5A, "R6 readback reg3");

    wr_op(P_IDX, 8'h80); wr_op(P_DAT, 8'h11); rd_op(P_DAT, 8'h8F, "R7 reg0 read-only");
    wr_op(P_IDX, 8'h82); wr_op(P_DAT, 8'h22);
    wr_op(P_IDX, 8'h84); wr_op(P_DAT, 8'h33);
    wr_op(P_IDX, 8'h87); wr_op(P_DAT, 8'h44); rd_op(P_DAT, 8'h8A, "R7 reg7 read-only");
    check("R7 read-only regs unchanged", regs_o, packm());
    wr_op(P_IDX, 8'h81); wr_op(P_DAT, 8'h66); m[1] = 8'h66;
    rd_op(P_DAT, 8'h66, "R7 reg1 writable");

    wr_op(P_IDIN, 8'h00);
    check("R8 id zero sets prog", 128'(prog_mode), 1);
    rd_op(P_IDIN, 8'hFF, "R8 id-in read");
    wr_op(P_IDX, 8'h8A); wr_op(P_DAT, 8'hA5); m[10] = 8'hA5;
    check("R11 write with prog set", regs_o, packm());
    wr_op(P_IDIN, 8'h07);
    check("R8 id nonzero clears prog", 128'(prog_mode), 0);
    wr_op(P_IDX, 8'h89); wr_op(P_DAT, 8'hC3); m[9] = 8'hC3;
    check("R11 write with prog clear", regs_o, packm());

    rd_op(P_IDOUT, 8'h00, "R9 id-out read");
    wr_op(P_IDOUT, 8'h55);
    check("R9 id-out write regs", regs_o, packm());
    check("R9 id-out write index", 128'(index_o), 128'h89);

    wr_op(B + 16'h2, 8'h01);
    wr_op(B + 16'h10, 8'h02);
    check("R2 undecoded write index", 128'(index_o), 128'h89);
    check("R2 undecoded write regs", regs_o, packm());
    @(negedge clk); addr = B + 16'h14; rd = 1;
    @(negedge clk); rd = 0;
    check("R2 undecoded read", 128'({rvalid, rdata}), 128'({1'b0, 8'hFF}));

    repeat (3) @(negedge clk);
    check("R4 scoreboard drained", 128'(exp_q.size()), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule